// File: doc/BRIEF.md
# Serial Converter Auto Power-Down Sequencer

This block manages power for a converter with a serial interface. It watches chip select, the serial clock and serial data in, all sampled in the system clock domain. During a frame it captures a 15-bit control word. Two power-mode bits in that word select one of three behaviours: stay fully powered, drop into a deep shutdown, or drop into a light standby that keeps the reference alive. The low-power state is entered on the 15th serial-clock rising edge of a frame. It lasts as long as chip select stays low.

Raising chip select starts a wake-up. Track/hold goes back to track and a timer runs for the power-up interval of the state being left. That interval is a cycle count derived from the system clock frequency, and shutdown is much slower to leave than standby. A ready flag tells the host when a new conversion frame will be valid. A frame opened while ready is low sets a sticky invalid-conversion flag. The next frame opened while ready is high clears it.

Top module: `adc_pwr_seq`

## Requirements
- R1: After reset, pwr_state is 00 (active), ready is 1, ref_en is 1, trk_hold is 1 (track) and bad_conv is 0.
- R2: A frame begins on a falling edge of cs_n. The first 15 sclk rising edges shift in sdin, first bit into word bit 14. Bit 8 is the high mode bit, bit 7 the low mode bit and bit 3 the reference bit. The word takes effect on the 15th edge. Later edges in the same frame are ignored. A frame with fewer than 15 edges changes neither the stored word nor the state.
- R3: Mode bits 10 on the 15th edge give pwr_state 10 (shutdown), ref_en 0, trk_hold 0 (hold) and ready 0.
- R4: Mode bits 01 on the 15th edge give pwr_state 01 (standby), trk_hold 0 and ready 0. ref_en equals the reference bit.
- R5: Mode bits 00 or 11 cause no power-down. pwr_state stays 00 and ready stays 1.
- R6: A low-power state persists for as long as cs_n stays low.
- R7: A rising edge of cs_n in a low-power state gives pwr_state 11 (waking), trk_hold 1 and ready 0.
- R8: The waking state lasts ceil(T*CLK_HZ/1e9) clock cycles. T is SHUT_UP_NS when leaving shutdown and STBY_UP_NS when leaving standby. The block then returns to pwr_state 00 with ready 1.
- R9: A frame begun while ready is 0 sets bad_conv. A frame begun while ready is 1 clears it. Otherwise bad_conv holds its value.
- R10: The stored reference bit survives both low-power states, and ref_en reflects it again after wake-up.
- R11: A complete frame with mode bits 00 or 11 received while waking does not shorten the wake-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| sdin | input | 1 | Serial control data in |
| pwr_state | output | 2 | 00 active, 01 standby, 10 shutdown, 11 waking |
| ref_en | output | 1 | Reference enable |
| trk_hold | output | 1 | 1 track, 0 hold |
| ready | output | 1 | Power-up interval complete, conversion valid |
| bad_conv | output | 1 | Sticky flag for a frame started too early |

## Verification
The bound checker watches several invariants on every cycle:
- shutdown forces ref_en low;
- a low-power state always holds with ready low;
- a low-power state can only be left through the waking state;
- ready can only rise out of waking;
- bad_conv clears only while ready is high;
- the waking run never exceeds the longer power-up count.

Only the bench scenarios can show the rest:
- bit positions and the 15-edge capture rule;
- the exact wake-up window for each depth;
- retention of the reference bit;
- that a full-power frame sent during wake-up leaves the timer alone.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

   typedef enum logic [1:0] {
      PS_ACTIVE = 2'b00,
      PS_STBY   = 2'b01,
      PS_SHUT   = 2'b10,
      PS_WAKE   = 2'b11
   } pstate_t;

   function automatic logic mode_is_shut(input logic [1:0] pm);
      return pm == 2'b10;
   endfunction

   function automatic logic mode_is_stby(input logic [1:0] pm);
      return pm == 2'b01;
   endfunction

   function automatic logic is_low_power(input logic [1:0] st);
      return (st == PS_SHUT) || (st == PS_STBY);
   endfunction

endpackage

// File: rtl/adc_pwr_sync.sv
module adc_pwr_sync #(
   parameter int unsigned      WIDTH   = 3,
   parameter int unsigned      STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= RST_VAL;
            end else begin
               stage_q[0] <= d;
               for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign q = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/adc_pwr_rx.sv
module adc_pwr_rx #(
   parameter int unsigned WORD_BITS = 15,
   parameter int unsigned PM_HI_POS = 8,
   parameter int unsigned PM_LO_POS = 7,
   parameter int unsigned REF_POS   = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_start,
   input  logic       bit_stb,
   input  logic       bit_in,
   output logic       word_vld,
   output logic [1:0] word_pm,
   output logic       word_ref
);

   localparam int unsigned CW = $clog2(WORD_BITS + 1);

   generate
      if (WORD_BITS < 2 || PM_HI_POS >= WORD_BITS || PM_LO_POS >= WORD_BITS ||
          REF_POS >= WORD_BITS) begin : g_bad_cfg
         $error("adc_pwr_rx: field position outside the control word");
      end
   endgenerate

   logic [CW-1:0]        bit_cnt;
   logic [WORD_BITS-1:0] shreg;
   logic [WORD_BITS-1:0] full_word;

   assign full_word = {shreg[WORD_BITS-2:0], bit_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt  <= '0;
         shreg    <= '0;
         word_vld <= 1'b0;
         word_pm  <= 2'b00;
         word_ref <= 1'b1;
      end else begin
         word_vld <= 1'b0;
         if (frame_start) begin
            bit_cnt <= '0;
         end else if (bit_stb && (bit_cnt < CW'(WORD_BITS))) begin
            shreg   <= full_word;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == CW'(WORD_BITS - 1)) begin
               word_vld <= 1'b1;
               word_pm  <= {full_word[PM_HI_POS], full_word[PM_LO_POS]};
               word_ref <= full_word[REF_POS];
            end
         end
      end
   end

endmodule

// File: rtl/adc_pwr_tmr.sv
module adc_pwr_tmr #(
   parameter int unsigned SHUT_CYC = 62500,
   parameter int unsigned STBY_CYC = 88
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic from_shut,
   input  logic abort,
   output logic done
);

   localparam int unsigned MAX_CYC = (SHUT_CYC > STBY_CYC) ? SHUT_CYC : STBY_CYC;
   localparam int unsigned TW      = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

   generate
      if (SHUT_CYC < 1 || STBY_CYC < 1) begin : g_bad_cfg
         $error("adc_pwr_tmr: power-up counts must be at least one cycle");
      end
   endgenerate

   logic [TW-1:0] cnt;
   logic          run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         run <= 1'b0;
      end else if (load) begin
         cnt <= from_shut ? TW'(SHUT_CYC - 1) : TW'(STBY_CYC - 1);
         run <= 1'b1;
      end else if (abort) begin
         run <= 1'b0;
      end else if (run) begin
         if (cnt == '0) run <= 1'b0;
         else           cnt <= cnt - 1'b1;
      end
   end

   assign done = run && (cnt == '0);

endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
   import adc_pwr_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 125_000_000,
   parameter int unsigned SHUT_UP_NS  = 500_000,
   parameter int unsigned STBY_UP_NS  = 700,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned WORD_BITS   = 15,
   parameter int unsigned PM_HI_POS   = 8,
   parameter int unsigned PM_LO_POS   = 7,
   parameter int unsigned REF_POS     = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       sclk,
   input  logic       sdin,
   output logic [1:0] pwr_state,
   output logic       ref_en,
   output logic       trk_hold,
   output logic       ready,
   output logic       bad_conv
);

   localparam longint unsigned NS_PER_S = 64'd1_000_000_000;
   localparam longint unsigned SHUT_L   =
      (longint'(SHUT_UP_NS) * longint'(CLK_HZ) + NS_PER_S - 1) / NS_PER_S;
   localparam longint unsigned STBY_L   =
      (longint'(STBY_UP_NS) * longint'(CLK_HZ) + NS_PER_S - 1) / NS_PER_S;
   localparam int unsigned SHUT_CYC = (SHUT_L < 1) ? 1 : int'(SHUT_L);
   localparam int unsigned STBY_CYC = (STBY_L < 1) ? 1 : int'(STBY_L);

   generate
      if (CLK_HZ == 0) begin : g_bad_clk
         $error("adc_pwr_seq: CLK_HZ must be nonzero");
      end
   endgenerate

   // ---------------- input sampling and edge detection ----------------
   logic [2:0] pins_s;
   logic       cs_s, sclk_s, sd_s;
   logic       cs_q, sclk_q;

   adc_pwr_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, sclk, sdin}),
      .q     (pins_s)
   );

   assign {cs_s, sclk_s, sd_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q   <= 1'b1;
         sclk_q <= 1'b0;
      end else begin
         cs_q   <= cs_s;
         sclk_q <= sclk_s;
      end
   end

   logic cs_fall, cs_rise, sclk_rise;
   assign cs_fall   = cs_q & ~cs_s;
   assign cs_rise   = ~cs_q & cs_s;
   assign sclk_rise = ~sclk_q & sclk_s & ~cs_s;

   // ---------------- control word capture ----------------
   logic       word_vld;
   logic [1:0] word_pm;
   logic       word_ref;

   adc_pwr_rx #(
      .WORD_BITS (WORD_BITS),
      .PM_HI_POS (PM_HI_POS),
      .PM_LO_POS (PM_LO_POS),
      .REF_POS   (REF_POS)
   ) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (cs_fall),
      .bit_stb     (sclk_rise),
      .bit_in      (sd_s),
      .word_vld    (word_vld),
      .word_pm     (word_pm),
      .word_ref    (word_ref)
   );

   // ---------------- power sequencing ----------------
   pstate_t state;
   logic    ref_q, ready_q, trk_q, bad_q;
   logic    low_pwr, pdn, wake_go, tmr_done;

   assign low_pwr = is_low_power(state);
   assign pdn     = word_vld && !low_pwr &&
                    (mode_is_shut(word_pm) || mode_is_stby(word_pm));
   assign wake_go = cs_rise && low_pwr;

   adc_pwr_tmr #(
      .SHUT_CYC (SHUT_CYC),
      .STBY_CYC (STBY_CYC)
   ) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (wake_go),
      .from_shut (state == PS_SHUT),
      .abort     (pdn),
      .done      (tmr_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= PS_ACTIVE;
         ref_q   <= 1'b1;
         ready_q <= 1'b1;
         trk_q   <= 1'b1;
         bad_q   <= 1'b0;
      end else begin
         if (word_vld) ref_q <= word_ref;
         if (cs_fall)  bad_q <= ~ready_q;
         if (pdn) begin
            state   <= mode_is_shut(word_pm) ? PS_SHUT : PS_STBY;
            ready_q <= 1'b0;
            trk_q   <= 1'b0;
         end else if (wake_go) begin
            state   <= PS_WAKE;
            trk_q   <= 1'b1;
         end else if (state == PS_WAKE && tmr_done) begin
            state   <= PS_ACTIVE;
            ready_q <= 1'b1;
         end
      end
   end

   assign pwr_state = state;
   assign ref_en    = ref_q && (state != PS_SHUT);
   assign trk_hold  = trk_q;
   assign ready     = ready_q;
   assign bad_conv  = bad_q;

endmodule

// File: rtl/adc_pwr_seq_chk.sv
module adc_pwr_seq_chk
   import adc_pwr_pkg::*;
#(
   parameter int unsigned MAX_WAKE = 1
) (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] pwr_state,
   input logic       ref_en,
   input logic       trk_hold,
   input logic       ready,
   input logic       bad_conv
);

   logic        low_pwr;
   int unsigned wake_run;

   assign low_pwr = (pwr_state == PS_SHUT) || (pwr_state == PS_STBY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  wake_run <= 0;
      else if (pwr_state == PS_WAKE) wake_run <= wake_run + 1;
      else                         wake_run <= 0;
   end

   AST_SHUT_REF_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == PS_SHUT) |-> !ref_en); // R3

   AST_LOWPWR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      low_pwr |-> (!trk_hold && !ready)); // R4

   AST_LOWPWR_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(low_pwr) && !low_pwr) |-> (pwr_state == PS_WAKE)); // R7

   AST_READY_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> ($past(pwr_state) == PS_WAKE)); // R8

   AST_WAKE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      wake_run <= MAX_WAKE); // R8

   AST_BAD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bad_conv) |-> ready); // R9

endmodule

bind adc_pwr_seq adc_pwr_seq_chk #(
   .MAX_WAKE (SHUT_CYC)
) u_pwr_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pwr_state (pwr_state),
   .ref_en    (ref_en),
   .trk_hold  (trk_hold),
   .ready     (ready),
   .bad_conv  (bad_conv)
);

// File: tb/adc_pwr_seq_tb_top.sv
`timescale 1ns/1ps
module adc_pwr_seq_tb_top;

   localparam int unsigned CLK_HZ  = 125_000_000;
   localparam int unsigned SHUT_NS = 4000;
   localparam int unsigned STBY_NS = 700;
   localparam int SHUT_N = int'((64'(SHUT_NS) * 64'(CLK_HZ) + 64'd999_999_999) / 64'd1_000_000_000);
   localparam int STBY_N = int'((64'(STBY_NS) * 64'(CLK_HZ) + 64'd999_999_999) / 64'd1_000_000_000);

   // {pm[1:0], ref, exp_state[1:0], exp_ref_en, exp_trk, exp_ready}
   localparam logic [7:0] VEC [6] = '{
      8'b00_1_00_1_1_1,
      8'b01_1_01_1_0_0,
      8'b10_1_10_0_0_0,
      8'b11_1_00_1_1_1,
      8'b01_0_01_0_0_0,
      8'b00_0_00_0_1_1
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       sclk = 1'b0;
   logic       sdin = 1'b0;
   logic [1:0] pwr_state;
   logic       ref_en, trk_hold, ready, bad_conv;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   adc_pwr_seq #(
      .CLK_HZ     (CLK_HZ),
      .SHUT_UP_NS (SHUT_NS),
      .STBY_UP_NS (STBY_NS)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (cs_n),
      .sclk      (sclk),
      .sdin      (sdin),
      .pwr_state (pwr_state),
      .ref_en    (ref_en),
      .trk_hold  (trk_hold),
      .ready     (ready),
      .bad_conv  (bad_conv)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [14:0] mk_word(input logic [1:0] pm, input logic rbit);
      logic [14:0] w;
      w    = '0;
      w[8] = pm[1];
      w[7] = pm[0];
      w[3] = rbit;
      return w;
   endfunction

   // Opens a frame and clocks nedge bits; cs_n is left low.
   task automatic frame(input logic [14:0] w, input int nedge);
      cs_n = 1'b0;
      tick(4);
      for (int i = 0; i < nedge; i++) begin
         sdin = (i < 15) ? w[14-i] : 1'b1;
         tick(4);
         sclk = 1'b1;
         tick(4);
         sclk = 1'b0;
      end
      sdin = 1'b0;
      tick(10);
   endtask

   initial begin : watchdog
      for (int c = 0; c < 150_000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : stim
      tick(5);
      rst_n = 1'b1;
      tick(3);
      chk("R1 state",    32'(pwr_state), 32'h0);
      chk("R1 ready",    32'(ready),     32'h1);
      chk("R1 ref_en",   32'(ref_en),    32'h1);
      chk("R1 trk_hold", 32'(trk_hold),  32'h1);
      chk("R1 bad_conv", 32'(bad_conv),  32'h0);

      for (int i = 0; i < 6; i++) begin
         logic [1:0] pm;
         logic       rb;
         string      tg;
         int         nw;
         pm = VEC[i][7:6];
         rb = VEC[i][5];
         tg = (pm == 2'b10) ? "R3" : (pm == 2'b01) ? "R4" : "R5";
         frame(mk_word(pm, rb), 16);
         chk({tg, " state"},  32'(pwr_state), 32'(VEC[i][4:3]));
         chk({tg, " ref_en"}, 32'(ref_en),    32'(VEC[i][2]));
         chk({tg, " trk"},    32'(trk_hold),  32'(VEC[i][1]));
         chk({tg, " ready"},  32'(ready),     32'(VEC[i][0]));
         if (VEC[i][0] == 1'b0) begin
            tick(50);
            chk("R6 held low", 32'(pwr_state), 32'(VEC[i][4:3]));
            nw = (pm == 2'b10) ? SHUT_N : STBY_N;
            cs_n = 1'b1;
            tick(5);
            chk("R7 state", 32'(pwr_state), 32'h3);
            chk("R7 trk",   32'(trk_hold),  32'h1);
            chk("R7 ready", 32'(ready),     32'h0);
            tick(nw - 15);
            chk("R8 early ready", 32'(ready), 32'h0);
            tick(20);
            chk("R8 late ready", 32'(ready),     32'h1);
            chk("R8 state",      32'(pwr_state), 32'h0);
            chk("R10 ref kept",  32'(ref_en),    32'(rb));
         end else begin
            cs_n = 1'b1;
            tick(5);
            chk("R5 after frame", 32'(ready), 32'h1);
         end
      end

      // R2: short frame of 14 edges leaves word and state alone (stored ref is 0)
      frame(mk_word(2'b10, 1'b1), 14);
      chk("R2 short state",  32'(pwr_state), 32'h0);
      chk("R2 short ready",  32'(ready),     32'h1);
      chk("R2 short ref_en", 32'(ref_en),    32'h0);
      cs_n = 1'b1;
      tick(5);

      // R2: edges after the 15th (with sdin high) are ignored
      frame(mk_word(2'b01, 1'b1), 20);
      chk("R2 extra state",  32'(pwr_state), 32'h1);
      chk("R2 extra ref_en", 32'(ref_en),    32'h1);
      cs_n = 1'b1;
      tick(STBY_N + 20);
      chk("R2 extra wake", 32'(ready), 32'h1);

      // R9 / R11: frame during shutdown wake-up
      frame(mk_word(2'b10, 1'b1), 16);
      chk("R3 shut again", 32'(pwr_state), 32'h2);
      cs_n = 1'b1;
      tick(10);
      frame(mk_word(2'b00, 1'b1), 16);
      chk("R9 set",        32'(bad_conv),  32'h1);
      chk("R11 waking",    32'(pwr_state), 32'h3);
      chk("R11 ready low", 32'(ready),     32'h0);
      cs_n = 1'b1;
      tick(SHUT_N);
      chk("R11 woke",     32'(pwr_state), 32'h0);
      chk("R9 sticky",    32'(bad_conv),  32'h1);
      frame(mk_word(2'b00, 1'b1), 16);
      chk("R9 cleared",   32'(bad_conv),  32'h0);
      chk("R5 full on",   32'(ready),     32'h1);
      cs_n = 1'b1;
      tick(5);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule